// File: doc/BRIEF.md
# Power Register Access Command Packer

This block acts for a host that wants to read, write or read-modify-write a short list of power-controller registers through a shared mailbox. A single request holds one to five 16-bit register addresses, their data bytes (or value/mask pairs), an operation code and a layout select. The block packs everything into a byte payload and stores it, word by word, into the mailbox write buffer. It then writes one command word and polls the mailbox status until the busy flag clears or a retry limit runs out. For a read, it fetches the mailbox read buffer and picks out one result byte per register.

Two payload layouts are supported. The interleaved layout emits each entry as a full group: address, then that entry's data. The packed layout places every address first and the data after them. Each layout has its own size rule and its own result positions in the read buffer. The mailbox sits outside the block and is reached through a simple request/acknowledge register bus. The requester sees a start pulse in and a one-cycle done pulse out, along with an error code and the read results.

Top module: `pwr_cmd_packer`

## Requirements
- R1: After reset, `done`, `bus_req`, `err_code` and `rd_data` are all zero.
- R2: The command word is written to bus offset 0x00. It carries the payload byte count in bits 23:16, the operation id in bits 15:12 (write 0, read 1, read-modify-write 2), zero in bit 8 (no completion interrupt), 0xFF in bits 7:0, and zero in all other bits.
- R3: Interleaved layout (`layout`=0). Entry i contributes bytes in this order: address low, address high, then its data. A write adds data byte i. A read-modify-write adds a value byte from data byte 2i and then a mask byte from data byte 2i+1. A read adds no data. The size is count×2 for a read, count×3 for a write and count×4 for a read-modify-write.
- R4: Packed layout (`layout`=1), read or write. Address i goes to payload bytes 2i (low) and 2i+1 (high). For a write, data byte i goes to payload byte 2×count+i. The size is 2×count for a read and 3×count for a write.
- R5: Packed layout, read-modify-write. Only entry 0 is sent: address low, address high, value (data byte 0), mask (data byte 1). The size is 4 whatever the count.
- R6: Payload byte 4k+j appears in bits 8j+7:8j of the word written to offset 0x80+4k. Words are written in ascending k. Exactly ceil(size/4) words are written, and unused bytes are zero. All payload words are written before the command word. The bus request holds its address steady until it is acknowledged.
- R7: After the command, status is read at offset 0x04, where bit 0 is busy. After each busy reading, the block leaves `POLL_GAP` cycles without a request before it reads status again.
- R8: If status still shows busy after `POLL_LIMIT`+1 readings, the block ends with `err_code`=1 (timeout) and does not read the read buffer. A busy count of exactly `POLL_LIMIT` readings still completes normally.
- R9: If busy is clear and status bit 1 is set, the block ends with `err_code`=2 (I/O error) and does not read the read buffer.
- R10: On a successful read, the block reads all four read-buffer words, ascending from offset 0x90. In the interleaved layout, result i (`rd_data` bits 8i+7:8i) is read-buffer byte 2+3i. Results for i ≥ count are zero. A successful write or read-modify-write reads no buffer and leaves `rd_data` zero.
- R11: In the packed layout, read result i is read-buffer byte i, for i < count.
- R12: A request with count 0, a count above 5, or op 3 causes no bus access and ends with `done` and `err_code`=3.
- R13: A `start` that arrives while an operation is in flight is ignored. No second command is issued, and the first request's fields are used.
- R14: `done` is a one-cycle pulse. `err_code` and `rd_data` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| layout | input | 1 | 0 interleaved, 1 packed payload |
| op | input | 2 | 0 write, 1 read, 2 read-modify-write |
| count | input | 3 | Number of register entries (1 to 5) |
| addr_list | input | 80 | Address of entry i at bits 16i+15:16i |
| data_list | input | 80 | Data byte k at bits 8k+7:8k |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 I/O error, 3 bad request |
| rd_data | output | 40 | Read result i at bits 8i+7:8i |
| bus_req | output | 1 | Mailbox bus request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | 8 | Mailbox byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access acknowledge, read data valid with it |
| bus_rdata | input | 32 | Read data |

## Verification
The packer runs with every operation in both layouts. Counts of 1, 2, 3 and 5 make the last payload word partial, full, or absent, so a wrong byte stride, an off-by-one word count or a missing zero-fill shows up as a mismatched word or an extra write. Two read requests carry the same addresses and produce identical payloads; they differ only in layout, so only the read-back offsets can tell them apart. A packed read-modify-write with a count of 3 confirms that only the first entry is sent.

Status streams are mixed across the runs:
- no busy readings;
- a few busy readings, with their spacing measured;
- exactly the retry limit, which must still succeed;
- busy forever, which must time out;
- busy followed by the error bit, which must report an I/O error.

Invalid requests and a second start issued mid-operation complete the set.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   localparam logic [7:0] MSG_PWR = 8'hFF;

   typedef enum logic [1:0] {
      OP_WR  = 2'd0,
      OP_RD  = 2'd1,
      OP_RMW = 2'd2,
      OP_BAD = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      ERR_NONE    = 2'd0,
      ERR_TIMEOUT = 2'd1,
      ERR_IO      = 2'd2,
      ERR_BADREQ  = 2'd3
   } err_e;

   typedef enum logic [2:0] {
      S_IDLE, S_WBUF, S_CMD, S_STAT, S_GAP, S_RBUF, S_DONE
   } st_e;
endpackage

// File: rtl/pwr_pack.sv
module pwr_pack
   import pwr_pkg::*;
#(
   parameter int MAX_ENT = 5,
   localparam int CW        = $clog2(MAX_ENT + 1),
   localparam int PAY_BYTES = 4 * MAX_ENT,
   localparam int SZW       = $clog2(PAY_BYTES + 1)
) (
   input  logic                    layout,
   input  logic [1:0]              op,
   input  logic [CW-1:0]           cnt,
   input  logic [MAX_ENT*16-1:0]   addr_list,
   input  logic [MAX_ENT*16-1:0]   data_list,
   output logic [PAY_BYTES*8-1:0]  pay,
   output logic [SZW-1:0]          size
);
   always_comb begin
      pay  = '0;
      size = '0;
      if (!layout) begin
         for (int i = 0; i < MAX_ENT; i++) begin
            if (CW'(i) < cnt) begin
               case (op)
                  OP_RD:   pay[16*i +: 16] = addr_list[16*i +: 16];
                  OP_WR:   pay[24*i +: 24] = {data_list[8*i +: 8], addr_list[16*i +: 16]};
                  OP_RMW:  pay[32*i +: 32] = {data_list[16*i +: 16], addr_list[16*i +: 16]};
                  default: ;
               endcase
            end
         end
         case (op)
            OP_RD:   size = SZW'(2 * int'(cnt));
            OP_WR:   size = SZW'(3 * int'(cnt));
            OP_RMW:  size = SZW'(4 * int'(cnt));
            default: size = '0;
         endcase
      end else if (op == OP_RMW) begin
         pay[31:0] = {data_list[15:0], addr_list[15:0]};
         size      = SZW'(4);
      end else if (op != OP_BAD) begin
         for (int i = 0; i < MAX_ENT; i++) begin
            if (CW'(i) < cnt) begin
               pay[16*i +: 16] = addr_list[16*i +: 16];
               if (op == OP_WR)
                  pay[8*(2*int'(cnt) + i) +: 8] = data_list[8*i +: 8];
            end
         end
         size = (op == OP_WR) ? SZW'(3 * int'(cnt)) : SZW'(2 * int'(cnt));
      end
   end
endmodule

// File: rtl/pwr_unpack.sv
module pwr_unpack #(
   parameter int MAX_ENT   = 5,
   parameter int RB_BYTES  = 16,
   parameter int RD_FIRST  = 2,
   parameter int RD_STRIDE = 3,
   localparam int CW       = $clog2(MAX_ENT + 1)
) (
   input  logic                  layout,
   input  logic [CW-1:0]         cnt,
   input  logic [RB_BYTES*8-1:0] rbuf,
   output logic [MAX_ENT*8-1:0]  rd
);
   if (RD_FIRST + RD_STRIDE * (MAX_ENT - 1) >= RB_BYTES) begin : g_bad_stride
      $error("interleaved read offsets exceed the read buffer");
   end
   if (MAX_ENT > RB_BYTES) begin : g_bad_packed
      $error("packed read offsets exceed the read buffer");
   end

   for (genvar g = 0; g < MAX_ENT; g++) begin : g_ent
      localparam int IL_OFF = RD_FIRST + RD_STRIDE * g;
      assign rd[8*g +: 8] = (CW'(g) >= cnt) ? 8'h00 :
                            layout ? rbuf[8*g +: 8] : rbuf[8*IL_OFF +: 8];
   end
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
   import pwr_pkg::*;
#(
   parameter int          MAX_ENT    = 5,
   parameter int          RB_BYTES   = 16,
   parameter int          BUS_AW     = 8,
   parameter int          POLL_LIMIT = 100000,
   parameter int          POLL_GAP   = 4,
   parameter logic [7:0]  CMD_OFF    = 8'h00,
   parameter logic [7:0]  STAT_OFF   = 8'h04,
   parameter logic [7:0]  WB_OFF     = 8'h80,
   parameter logic [7:0]  RB_OFF     = 8'h90,
   localparam int CW        = $clog2(MAX_ENT + 1),
   localparam int PAY_BYTES = 4 * MAX_ENT,
   localparam int PAY_WORDS = MAX_ENT,
   localparam int SZW       = $clog2(PAY_BYTES + 1),
   localparam int SZW1      = SZW + 1,
   localparam int NWW       = $clog2(PAY_WORDS + 1),
   localparam int RB_WORDS  = RB_BYTES / 4,
   localparam int RIW       = $clog2(RB_WORDS),
   localparam int PW        = $clog2(POLL_LIMIT + 1),
   localparam int GW        = $clog2(POLL_GAP + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   layout,
   input  logic [1:0]             op,
   input  logic [CW-1:0]          cnt,
   input  logic [PAY_BYTES*8-1:0] pay,
   input  logic [SZW-1:0]         size,
   output logic                   done,
   output logic [1:0]             err_code,
   output logic                   layout_q,
   output logic [CW-1:0]          cnt_q,
   output logic [RB_BYTES*8-1:0]  rbuf_q,
   output logic                   bus_req,
   output logic                   bus_we,
   output logic [BUS_AW-1:0]      bus_addr,
   output logic [31:0]            bus_wdata,
   input  logic                   bus_ack,
   input  logic [31:0]            bus_rdata
);
   st_e             state_q;
   err_e            err_q;
   logic [1:0]      op_q;
   logic [SZW-1:0]  size_q;
   logic [31:0]     pay_q [PAY_WORDS];
   logic [NWW-1:0]  nwords_q, widx_q;
   logic [RIW-1:0]  ridx_q;
   logic [PW-1:0]   polls_q;
   logic [GW-1:0]   gap_q;
   logic            req_ok;
   logic [31:0]     cmd_w;

   assign req_ok = (cnt != '0) && (int'(cnt) <= MAX_ENT) && (op != OP_BAD);
   assign cmd_w  = {8'h00, 8'(size_q), 4'(op_q), 3'b000, 1'b0, MSG_PWR};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         err_q    <= ERR_NONE;
         op_q     <= '0;
         layout_q <= 1'b0;
         cnt_q    <= '0;
         size_q   <= '0;
         nwords_q <= '0;
         widx_q   <= '0;
         ridx_q   <= '0;
         polls_q  <= '0;
         gap_q    <= '0;
         rbuf_q   <= '0;
         for (int k = 0; k < PAY_WORDS; k++) pay_q[k] <= '0;
      end else begin
         case (state_q)
            S_IDLE: if (start) begin
               rbuf_q <= '0;
               if (!req_ok) begin
                  err_q   <= ERR_BADREQ;
                  state_q <= S_DONE;
               end else begin
                  err_q    <= ERR_NONE;
                  op_q     <= op;
                  layout_q <= layout;
                  cnt_q    <= cnt;
                  size_q   <= size;
                  nwords_q <= NWW'((SZW1'(size) + SZW1'(3)) >> 2);
                  widx_q   <= '0;
                  for (int k = 0; k < PAY_WORDS; k++) pay_q[k] <= pay[32*k +: 32];
                  state_q  <= S_WBUF;
               end
            end
            S_WBUF: if (bus_ack) begin
               if (widx_q == nwords_q - NWW'(1)) state_q <= S_CMD;
               else                              widx_q  <= widx_q + NWW'(1);
            end
            S_CMD: if (bus_ack) begin
               polls_q <= '0;
               state_q <= S_STAT;
            end
            S_STAT: if (bus_ack) begin
               if (bus_rdata[0]) begin
                  if (polls_q == PW'(POLL_LIMIT)) begin
                     err_q   <= ERR_TIMEOUT;
                     state_q <= S_DONE;
                  end else begin
                     polls_q <= polls_q + PW'(1);
                     gap_q   <= '0;
                     state_q <= S_GAP;
                  end
               end else if (bus_rdata[1]) begin
                  err_q   <= ERR_IO;
                  state_q <= S_DONE;
               end else if (op_q == OP_RD) begin
                  ridx_q  <= '0;
                  state_q <= S_RBUF;
               end else begin
                  state_q <= S_DONE;
               end
            end
            S_GAP: begin
               gap_q <= gap_q + GW'(1);
               if (gap_q == GW'(POLL_GAP - 1)) state_q <= S_STAT;
            end
            S_RBUF: if (bus_ack) begin
               rbuf_q[32*ridx_q +: 32] <= bus_rdata;
               if (ridx_q == RIW'(RB_WORDS - 1)) state_q <= S_DONE;
               else                              ridx_q  <= ridx_q + RIW'(1);
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (state_q)
         S_WBUF: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = BUS_AW'(WB_OFF) + BUS_AW'(4 * int'(widx_q));
            bus_wdata = pay_q[widx_q];
         end
         S_CMD: begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = BUS_AW'(CMD_OFF);
            bus_wdata = cmd_w;
         end
         S_STAT: begin
            bus_req  = 1'b1;
            bus_addr = BUS_AW'(STAT_OFF);
         end
         S_RBUF: begin
            bus_req  = 1'b1;
            bus_addr = BUS_AW'(RB_OFF) + BUS_AW'(4 * int'(ridx_q));
         end
         default: ;
      endcase
   end

   assign done     = (state_q == S_DONE);
   assign err_code = err_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R6
   AST_CMD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == BUS_AW'(CMD_OFF)) |-> (widx_q == nwords_q - NWW'(1))); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R14
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_GAP) |-> (polls_q <= PW'(POLL_LIMIT))); // R8
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != S_IDLE) |=> ($stable(op_q) && $stable(cnt_q))); // R13
   AST_RBUF_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_RBUF) |-> (op_q == OP_RD && err_q == ERR_NONE)); // R10
   AST_BADREQ_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && start && !req_ok) |=> (!bus_req && done)); // R12
endmodule

// File: rtl/pwr_cmd_packer.sv
module pwr_cmd_packer
   import pwr_pkg::*;
#(
   parameter int          MAX_ENT    = 5,
   parameter int          RB_BYTES   = 16,
   parameter int          RD_FIRST   = 2,
   parameter int          RD_STRIDE  = 3,
   parameter int          BUS_AW     = 8,
   parameter int          POLL_LIMIT = 100000,
   parameter int          POLL_GAP   = 4,
   parameter logic [7:0]  CMD_OFF    = 8'h00,
   parameter logic [7:0]  STAT_OFF   = 8'h04,
   parameter logic [7:0]  WB_OFF     = 8'h80,
   parameter logic [7:0]  RB_OFF     = 8'h90,
   localparam int CW        = $clog2(MAX_ENT + 1),
   localparam int PAY_BYTES = 4 * MAX_ENT,
   localparam int SZW       = $clog2(PAY_BYTES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  layout,
   input  logic [1:0]            op,
   input  logic [CW-1:0]         count,
   input  logic [MAX_ENT*16-1:0] addr_list,
   input  logic [MAX_ENT*16-1:0] data_list,
   output logic                  done,
   output logic [1:0]            err_code,
   output logic [MAX_ENT*8-1:0]  rd_data,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic [BUS_AW-1:0]     bus_addr,
   output logic [31:0]           bus_wdata,
   input  logic                  bus_ack,
   input  logic [31:0]           bus_rdata
);
   if (POLL_GAP < 1) begin : g_chk_gap
      $error("POLL_GAP must be at least one cycle");
   end
   if (PAY_BYTES > 255) begin : g_chk_size
      $error("payload size must fit the 8-bit size field");
   end
   if (RB_BYTES % 4 != 0 || RB_BYTES < 8) begin : g_chk_rb
      $error("read buffer must be a whole number of words, at least two");
   end
   if (WB_OFF[1:0] != 2'b00 || RB_OFF[1:0] != 2'b00) begin : g_chk_align
      $error("buffer offsets must be word aligned");
   end

   logic [PAY_BYTES*8-1:0] pay;
   logic [SZW-1:0]         size;
   logic                   layout_q;
   logic [CW-1:0]          cnt_q;
   logic [RB_BYTES*8-1:0]  rbuf_q;

   pwr_pack #(.MAX_ENT(MAX_ENT)) u_pack (
      .layout    (layout),
      .op        (op),
      .cnt       (count),
      .addr_list (addr_list),
      .data_list (data_list),
      .pay       (pay),
      .size      (size)
   );

   pwr_seq #(
      .MAX_ENT(MAX_ENT), .RB_BYTES(RB_BYTES), .BUS_AW(BUS_AW),
      .POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP),
      .CMD_OFF(CMD_OFF), .STAT_OFF(STAT_OFF), .WB_OFF(WB_OFF), .RB_OFF(RB_OFF)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .layout    (layout),
      .op        (op),
      .cnt       (count),
      .pay       (pay),
      .size      (size),
      .done      (done),
      .err_code  (err_code),
      .layout_q  (layout_q),
      .cnt_q     (cnt_q),
      .rbuf_q    (rbuf_q),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

   pwr_unpack #(
      .MAX_ENT(MAX_ENT), .RB_BYTES(RB_BYTES), .RD_FIRST(RD_FIRST), .RD_STRIDE(RD_STRIDE)
   ) u_unpack (
      .layout (layout_q),
      .cnt    (cnt_q),
      .rbuf   (rbuf_q),
      .rd     (rd_data)
   );
endmodule

// File: tb/pwr_cmd_packer_tb.sv
`timescale 1ns/1ps
module pwr_cmd_packer_tb_top;
   localparam int LIM = 6;
   localparam int GAP = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        layout = 1'b0;
   logic [1:0]  op = 2'd0;
   logic [2:0]  count = 3'd0;
   logic [79:0] addr_list = {16'h0102, 16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
   logic [79:0] data_list = 80'hA9A8A7A6A5A4A3A2A1A0;
   logic        done;
   logic [1:0]  err_code;
   logic [39:0] rd_data;
   logic        bus_req, bus_we;
   logic [7:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   pwr_cmd_packer #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .layout(layout), .op(op),
      .count(count), .addr_list(addr_list), .data_list(data_list),
      .done(done), .err_code(err_code), .rd_data(rd_data),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   // mailbox model
   logic        clr_m = 1'b0;
   int          cfg_busy = 0;
   logic        cfg_err = 1'b0;
   logic        cfg_stuck = 1'b0;
   logic [31:0] wb_m [8];
   logic [31:0] cmd_m;
   int n_wb, n_cmd, n_stat, n_rb, order_bad, busy_left;
   int cyc = 0, last_cyc, gmin, gmax;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (clr_m) begin
         for (int k = 0; k < 8; k++) wb_m[k] <= '0;
         cmd_m <= '0; n_wb <= 0; n_cmd <= 0; n_stat <= 0; n_rb <= 0;
         order_bad <= 0; busy_left <= cfg_busy; gmin <= 999; gmax <= 0;
         bus_ack <= 1'b0;
      end else if (bus_req && !bus_ack) begin
         bus_ack <= 1'b1;
         if (bus_we) begin
            if (bus_addr == 8'h00) begin
               cmd_m <= bus_wdata; n_cmd <= n_cmd + 1;
            end else if (bus_addr >= 8'h80 && bus_addr < 8'h94) begin
               wb_m[(bus_addr - 8'h80) >> 2] <= bus_wdata;
               n_wb <= n_wb + 1;
               if (n_cmd != 0) order_bad <= order_bad + 1;
            end
         end else if (bus_addr == 8'h04) begin
            n_stat <= n_stat + 1;
            last_cyc <= cyc;
            if (n_stat > 0) begin
               if (cyc - last_cyc < gmin) gmin <= cyc - last_cyc;
               if (cyc - last_cyc > gmax) gmax <= cyc - last_cyc;
            end
            if (cfg_stuck || busy_left > 0) begin
               bus_rdata <= 32'h1;
               busy_left <= busy_left - 1;
            end else begin
               bus_rdata <= {30'd0, cfg_err, 1'b0};
            end
         end else if (bus_addr >= 8'h90 && bus_addr < 8'hA0) begin
            bus_rdata <= {8'h13, 8'h12, 8'h11, 8'h10} + {4{8'(bus_addr - 8'h90)}};
            n_rb <= n_rb + 1;
         end
      end else begin
         bus_ack <= 1'b0;
      end
   end

   typedef struct packed {
      logic         lay;
      logic [1:0]   op;
      logic [2:0]   cnt;
      logic [2:0]   busy;
      logic [31:0]  cmd;
      logic [2:0]   nw;
      logic [159:0] words;
      logic [39:0]  rd;
   } vec_t;

   localparam vec_t VECS [11] = '{
      '{1'b0, 2'd0, 3'd2, 3'd0, 32'h000600FF, 3'd2, {96'h0, 32'h0000A156, 32'h78A01234}, 40'h0},
      '{1'b0, 2'd1, 3'd3, 3'd1, 32'h000610FF, 3'd2, {96'h0, 32'h00009ABC, 32'h56781234}, 40'h0000181512},
      '{1'b0, 2'd2, 3'd1, 3'd2, 32'h000420FF, 3'd1, {128'h0, 32'hA1A01234}, 40'h0},
      '{1'b0, 2'd0, 3'd5, 3'd0, 32'h000F00FF, 3'd4, {32'h0, 32'h00A40102, 32'hA3DEF0A2, 32'h9ABCA156, 32'h78A01234}, 40'h0},
      '{1'b1, 2'd1, 3'd2, 3'd3, 32'h000410FF, 3'd1, {128'h0, 32'h56781234}, 40'h0000001110},
      '{1'b1, 2'd0, 3'd3, 3'd0, 32'h000900FF, 3'd3, {64'h0, 32'h000000A2, 32'hA1A09ABC, 32'h56781234}, 40'h0},
      '{1'b1, 2'd2, 3'd1, 3'd0, 32'h000420FF, 3'd1, {128'h0, 32'hA1A01234}, 40'h0},
      '{1'b0, 2'd2, 3'd5, 3'd1, 32'h001420FF, 3'd5, {32'hA9A80102, 32'hA7A6DEF0, 32'hA5A49ABC, 32'hA3A25678, 32'hA1A01234}, 40'h0},
      '{1'b1, 2'd2, 3'd3, 3'd0, 32'h000420FF, 3'd1, {128'h0, 32'hA1A01234}, 40'h0},
      '{1'b1, 2'd1, 3'd5, 3'd2, 32'h000A10FF, 3'd3, {64'h0, 32'h00000102, 32'hDEF09ABC, 32'h56781234}, 40'h1413121110},
      '{1'b0, 2'd1, 3'd5, 3'd6, 32'h000A10FF, 3'd3, {64'h0, 32'h00000102, 32'hDEF09ABC, 32'h56781234}, 40'h1E1B181512}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic launch(input logic lay, input logic [1:0] o, input logic [2:0] c,
                         input int busy, input logic errb, input logic stuck);
      @(negedge clk);
      cfg_busy = busy; cfg_err = errb; cfg_stuck = stuck;
      clr_m = 1'b1;
      @(negedge clk);
      clr_m = 1'b0;
      layout = lay; op = o; count = c;
      start = 1'b1;
   endtask

   task automatic wait_done(input string req);
      bit got = 0;
      for (int k = 0; k < 3000 && !got; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (done) got = 1;
      end
      chk({req, " done seen"}, 64'(got), 64'd1);
   endtask

   initial begin
      #1000000;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 done", 64'(done), 0);
      chk("R1 bus_req", 64'(bus_req), 0);
      chk("R1 err_code", 64'(err_code), 0);
      chk("R1 rd_data", 64'(rd_data), 0);
      rst_n = 1'b1;

      // R2 R3 R4 R5 R6 R10 R11: vector table
      foreach (VECS[v]) begin
         launch(VECS[v].lay, VECS[v].op, VECS[v].cnt, int'(VECS[v].busy), 1'b0, 1'b0);
         wait_done($sformatf("R2 vec%0d", v));
         chk($sformatf("R2 vec%0d command word", v), 64'(cmd_m), 64'(VECS[v].cmd));
         chk($sformatf("R2 vec%0d one command", v), 64'(n_cmd), 1);
         chk($sformatf("R6 vec%0d word count", v), 64'(n_wb), 64'(VECS[v].nw));
         chk($sformatf("R6 vec%0d command last", v), 64'(order_bad), 0);
         for (int w = 0; w < 5; w++)
            chk($sformatf("R3 R4 R5 vec%0d word%0d", v, w), 64'(wb_m[w]), 64'(VECS[v].words[32*w +: 32]));
         chk($sformatf("R7 vec%0d status reads", v), 64'(n_stat), 64'(int'(VECS[v].busy) + 1));
         chk($sformatf("R10 vec%0d buffer reads", v), 64'(n_rb), (VECS[v].op == 2'd1) ? 64'd4 : 64'd0);
         chk($sformatf("R10 R11 vec%0d rd_data", v), 64'(rd_data), 64'(VECS[v].rd));
         chk($sformatf("R8 vec%0d err_code", v), 64'(err_code), 0);
         if (v == 4) begin
            chk("R7 poll spacing min", 64'(gmin), 64'(GAP + 2));
            chk("R7 poll spacing max", 64'(gmax), 64'(GAP + 2));
         end
      end

      // R14: done pulse, results held
      launch(1'b0, 2'd1, 3'd3, 0, 1'b0, 1'b0);
      wait_done("R14");
      @(negedge clk);
      chk("R14 done one cycle", 64'(done), 0);
      repeat (5) @(negedge clk);
      chk("R14 rd_data held", 64'(rd_data), 64'h0000181512);
      chk("R14 err_code held", 64'(err_code), 0);

      // R8 timeout
      launch(1'b0, 2'd1, 3'd1, 0, 1'b0, 1'b1);
      wait_done("R8");
      chk("R8 timeout code", 64'(err_code), 1);
      chk("R8 busy reads", 64'(n_stat), 64'(LIM + 1));
      chk("R8 no buffer read", 64'(n_rb), 0);
      chk("R8 rd_data zero", 64'(rd_data), 0);

      // R9 I/O error
      launch(1'b1, 2'd1, 3'd2, 2, 1'b1, 1'b0);
      wait_done("R9");
      chk("R9 io code", 64'(err_code), 2);
      chk("R9 no buffer read", 64'(n_rb), 0);
      chk("R9 rd_data zero", 64'(rd_data), 0);

      // R12 invalid requests
      launch(1'b0, 2'd0, 3'd0, 0, 1'b0, 1'b0);
      wait_done("R12 count0");
      chk("R12 count0 code", 64'(err_code), 3);
      chk("R12 count0 no bus", 64'(n_wb + n_cmd + n_stat), 0);
      launch(1'b1, 2'd1, 3'd6, 0, 1'b0, 1'b0);
      wait_done("R12 count6");
      chk("R12 count6 code", 64'(err_code), 3);
      chk("R12 count6 no bus", 64'(n_wb + n_cmd + n_stat), 0);
      launch(1'b0, 2'd3, 3'd2, 0, 1'b0, 1'b0);
      wait_done("R12 op3");
      chk("R12 op3 code", 64'(err_code), 3);
      chk("R12 op3 no bus", 64'(n_wb + n_cmd + n_stat), 0);

      // R13 start while in flight
      launch(1'b0, 2'd0, 3'd1, 4, 1'b0, 1'b0);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      op = 2'd1; count = 3'd2; start = 1'b1;
      wait_done("R13");
      chk("R13 first command kept", 64'(cmd_m), 64'h000300FF);
      repeat (12) @(negedge clk);
      chk("R13 single command", 64'(n_cmd), 1);
      chk("R13 no buffer read", 64'(n_rb), 0);

      $display("CHECKS %0d ERRORS %0d", n_checks, n_fails);
      $finish;
   end
endmodule